// File: doc/BRIEF.md
# Pattern-Matching GF(16) Log Converter

This block converts two nonzero elements of GF(2^4) into their discrete logarithms with respect to a primitive element alpha. It uses a systolic chain of pattern elements and needs no lookup ROM and no multiplier. Each element holds one stored pattern alpha^(4n), the exponent of that pattern and a field-polynomial select bit. All three are written through a small configuration port before operands are sent. Each element has four pipeline stages. At every stage both operands are compared, in parallel, with the stored pattern multiplied by alpha that stage's number of times, and a hit records the exponent.

Each operand travels down the chain with an exponent field and a sticky "found" flag. The first hit sets the flag and writes the exponent. Later hits are ignored, so the wrap-around alpha^15 = alpha^0 at the last stage of the last element cannot overwrite an earlier result. An operation bit rides along unchanged for the exponent arithmetic that follows this block. A new operand pair can enter every cycle, and results appear 16 cycles later.

Top module: `gf16_log_pipe`

## Requirements
- R1: The block accepts one operand pair per clock. The results for a pair presented before rising edge e are on the outputs after rising edge e+15, which is 16 register stages of latency.
- R2: With the polynomial x^4+x+1 selected, each element's rotation maps b to {b2, b1, b0^b3, b3} (bit 3 first). A nonzero operand v then yields found=1 and an exponent e in 0..14 with alpha^e = v.
- R3: With the polynomial x^4+x^3+1 selected, each element's rotation maps b to {b2^b3, b1, b0, b3}. A nonzero operand yields found=1 and its exponent under that field.
- R4: A zero operand never matches. Its found flag is 0 at the output and its exponent field is 0.
- R5: Only the first match sets the exponent. The operand 1 (alpha^0) reports exponent 0 and never 15.
- R6: The x and y operands are converted independently and at the same time. The result for one does not depend on the value of the other.
- R7: The operation bit leaves the block unchanged, in the same cycle as the results of its operand pair.
- R8: Reset clears every pipeline stage and all configuration. The outputs read found=0, exponent 0 and op 0 until new data has passed through.
- R9: A configuration write with cfg_we=1 stores the pattern, the exponent and the polynomial bit into the element chosen by cfg_idx. Element n with pattern alpha^(4n) and exponent 4n yields, at stage k, the exponent 4n+k: the upper two bits are n and the lower two bits are k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | 2 | Element selected by the write |
| cfg_pat | input | 4 | Stored pattern value |
| cfg_pow | input | 4 | Exponent of the stored pattern |
| cfg_poly | input | 1 | 0: x^4+x+1, 1: x^4+x^3+1 |
| x_in | input | 4 | First operand |
| y_in | input | 4 | Second operand |
| op_in | input | 1 | Operation bit carried along |
| x_pow | output | 4 | Exponent of first operand |
| x_hit | output | 1 | First operand was recognised |
| y_pow | output | 4 | Exponent of second operand |
| y_hit | output | 1 | Second operand was recognised |
| op_out | output | 1 | Delayed operation bit |

## Verification
The bench builds the block with its defaults: 4-bit symbols and four elements of four stages each. With these values all sixteen field values can be streamed back to back under both polynomials, and the comparison at the wrap-around stage, where alpha^15 equals alpha^0, is reached. A hand-written vector table covers the x^4+x+1 field, including zero operands and the operand 1. Full sweeps check every value against an independent exponent model at one pair per cycle.

// File: rtl/gf16_log_pipe.sv
module gf16_log_pipe #(
  parameter int W    = 4,
  parameter int NPE  = 4,
  parameter int NROT = 4,
  localparam int IW  = $clog2(NPE)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [IW-1:0] cfg_idx,
  input  logic [W-1:0]  cfg_pat,
  input  logic [W-1:0]  cfg_pow,
  input  logic          cfg_poly,
  input  logic [W-1:0]  x_in,
  input  logic [W-1:0]  y_in,
  input  logic          op_in,
  output logic [W-1:0]  x_pow,
  output logic          x_hit,
  output logic [W-1:0]  y_pow,
  output logic          y_hit,
  output logic          op_out
);
  localparam int DEPTH = NPE * NROT;

  typedef struct packed {
    logic [W-1:0] x, y, xp, yp;
    logic         xh, yh, op;
  } st_t;

  logic [W-1:0] pat_q [NPE];
  logic [W-1:0] pw_q  [NPE];
  logic         poly_q[NPE];
  logic [W-1:0] rp [NPE][NROT];
  st_t          st_q[DEPTH];

  function automatic logic [W-1:0] mul_a(input logic [W-1:0] b, input logic p);
    return p ? {b[2] ^ b[3], b[1], b[0], b[3]} : {b[2], b[1], b[0] ^ b[3], b[3]};
  endfunction

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < NPE; i++) begin
        pat_q[i]  <= '0;
        pw_q[i]   <= '0;
        poly_q[i] <= 1'b0;
      end
    end else if (cfg_we) begin
      pat_q[cfg_idx]  <= cfg_pat;
      pw_q[cfg_idx]   <= cfg_pow;
      poly_q[cfg_idx] <= cfg_poly;
    end

  for (genvar n = 0; n < NPE; n++) begin : g_pe
    assign rp[n][0] = pat_q[n];
    for (genvar k = 1; k < NROT; k++) begin : g_rot
      assign rp[n][k] = mul_a(rp[n][k-1], poly_q[n]);
    end
  end

  st_t entry;
  assign entry = '{x: x_in, y: y_in, xp: '0, yp: '0, xh: 1'b0, yh: 1'b0, op: op_in};

  for (genvar s = 0; s < DEPTH; s++) begin : g_stg
    localparam int N = s / NROT;
    localparam int K = s % NROT;
    st_t sin, sd;
    if (s == 0) begin : g_first
      assign sin = entry;
    end else begin : g_next
      assign sin = st_q[s-1];
    end

    always_comb begin
      sd = sin;
      if (!sin.xh && |sin.x && sin.x == rp[N][K]) begin
        sd.xh = 1'b1;
        sd.xp = pw_q[N] + W'(K);
      end
      if (!sin.yh && |sin.y && sin.y == rp[N][K]) begin
        sd.yh = 1'b1;
        sd.yp = pw_q[N] + W'(K);
      end
    end

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) st_q[s] <= '0;
      else        st_q[s] <= sd;
  end

  assign x_pow  = st_q[DEPTH-1].xp;
  assign x_hit  = st_q[DEPTH-1].xh;
  assign y_pow  = st_q[DEPTH-1].yp;
  assign y_hit  = st_q[DEPTH-1].yh;
  assign op_out = st_q[DEPTH-1].op;
endmodule

// File: rtl/gf16_log_pipe_chk.sv
module gf16_log_pipe_chk #(
  parameter int W   = 4,
  parameter int LAT = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] x_in,
  input logic [W-1:0] y_in,
  input logic         op_in,
  input logic [W-1:0] x_pow,
  input logic         x_hit,
  input logic [W-1:0] y_pow,
  input logic         y_hit,
  input logic         op_out
);
  logic [LAT-1:0] zx_sr, zy_sr, op_sr;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      zx_sr <= '0;
      zy_sr <= '0;
      op_sr <= '0;
    end else begin
      zx_sr <= {zx_sr[LAT-2:0], x_in == '0};
      zy_sr <= {zy_sr[LAT-2:0], y_in == '0};
      op_sr <= {op_sr[LAT-2:0], op_in};
    end

  p_zero_x_nohit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    zx_sr[LAT-1] |-> !x_hit);
  p_zero_y_nohit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    zy_sr[LAT-1] |-> !y_hit);
  p_miss_pow_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!x_hit |-> x_pow == '0) and (!y_hit |-> y_pow == '0));
  p_op_delay_r7: assert property (@(posedge clk) disable iff (!rst_n)
    op_out == op_sr[LAT-1]);
  p_no_wrap_pow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (x_hit |-> x_pow != '1) and (y_hit |-> y_pow != '1));
endmodule

bind gf16_log_pipe gf16_log_pipe_chk #(.W(W), .LAT(NPE * NROT)) u_chk (
  .clk(clk), .rst_n(rst_n), .x_in(x_in), .y_in(y_in), .op_in(op_in),
  .x_pow(x_pow), .x_hit(x_hit), .y_pow(y_pow), .y_hit(y_hit), .op_out(op_out)
);

// File: tb/tb_gf16_log_pipe.sv
module tb_gf16_log_pipe;
  logic clk = 0, rst_n = 0;
  logic cfg_we = 0, cfg_poly = 0;
  logic [1:0] cfg_idx = 0;
  logic [3:0] cfg_pat = 0, cfg_pow = 0, x_in = 0, y_in = 0;
  logic op_in = 0;
  logic [3:0] x_pow, y_pow;
  logic x_hit, y_hit, op_out;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  gf16_log_pipe dut (.*);

  // x, y, op, exp_x, exp_y, hit_x, hit_y  (field x^4+x+1)
  localparam logic [18:0] VEC [12] = '{
    {4'd1,  4'd2,  1'b0, 4'd0,  4'd1,  1'b1, 1'b1},
    {4'd3,  4'd8,  1'b1, 4'd4,  4'd3,  1'b1, 1'b1},
    {4'd5,  4'd10, 1'b0, 4'd8,  4'd9,  1'b1, 1'b1},
    {4'd15, 4'd13, 1'b1, 4'd12, 4'd13, 1'b1, 1'b1},
    {4'd9,  4'd14, 1'b0, 4'd14, 4'd11, 1'b1, 1'b1},
    {4'd11, 4'd7,  1'b1, 4'd7,  4'd10, 1'b1, 1'b1},
    {4'd0,  4'd12, 1'b0, 4'd0,  4'd6,  1'b0, 1'b1},
    {4'd6,  4'd0,  1'b1, 4'd5,  4'd0,  1'b1, 1'b0},
    {4'd0,  4'd0,  1'b1, 4'd0,  4'd0,  1'b0, 1'b0},
    {4'd4,  4'd4,  1'b0, 4'd2,  4'd2,  1'b1, 1'b1},
    {4'd1,  4'd1,  1'b1, 4'd0,  4'd0,  1'b1, 1'b1},
    {4'd9,  4'd1,  1'b0, 4'd14, 4'd0,  1'b1, 1'b1}
  };

  function automatic logic [3:0] m_rot(input logic [3:0] b, input bit p);
    logic [4:0] t = {b, 1'b0};
    if (t[4]) t = t ^ (p ? 5'b11001 : 5'b10011);
    return t[3:0];
  endfunction

  function automatic logic [3:0] m_exp(input int e, input bit p);
    logic [3:0] b = 4'd1;
    for (int i = 0; i < e; i++) b = m_rot(b, p);
    return b;
  endfunction

  function automatic int m_log(input logic [3:0] v, input bit p);
    for (int e = 0; e < 15; e++) if (m_exp(e, p) == v) return e;
    return -1;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic check_out(input logic [3:0] xv, input logic [3:0] yv, input bit opv,
                           input bit p, input string tag);
    int lx = m_log(xv, p), ly = m_log(yv, p);
    chk(x_hit == (lx >= 0), {tag, " x_hit"}, x_hit, lx >= 0);
    chk(x_pow == (lx >= 0 ? lx[3:0] : 4'd0), {tag, " x_pow"}, x_pow, lx >= 0 ? lx : 0);
    chk(y_hit == (ly >= 0), {tag, " y_hit"}, y_hit, ly >= 0);
    chk(y_pow == (ly >= 0 ? ly[3:0] : 4'd0), {tag, " y_pow"}, y_pow, ly >= 0 ? ly : 0);
    chk(op_out == opv, "R7 op_out", op_out, opv);
  endtask

  task automatic load_cfg(input bit p);
    for (int n = 0; n < 4; n++) begin
      @(negedge clk);
      cfg_we = 1; cfg_idx = 2'(n); cfg_pat = m_exp(4 * n, p);
      cfg_pow = 4'(4 * n); cfg_poly = p;
    end
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic stream(input bit p, input string tag);
    for (int c = 0; c < 32; c++) begin
      @(negedge clk);
      if (c >= 16) check_out(4'(c - 16), 4'(31 - c), c[0], p, tag);
      if (c < 16) begin
        x_in = 4'(c); y_in = 4'(15 - c); op_in = c[0];
      end else begin
        x_in = 0; y_in = 0; op_in = 0;
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!x_hit && !y_hit && x_pow == 0 && y_pow == 0 && !op_out, "R8 reset outputs",
        {x_hit, y_hit, op_out}, 0);
    rst_n = 1;
    load_cfg(1'b0);
    foreach (VEC[i]) begin
      logic [18:0] v = VEC[i];
      @(negedge clk);
      x_in = v[18:15]; y_in = v[14:11]; op_in = v[10];
      repeat (16) @(posedge clk);
      @(negedge clk);
      chk(x_hit == v[1] && x_pow == v[9:6], "R2 R5 R6 table x", {x_hit, x_pow}, {v[1], v[9:6]});
      chk(y_hit == v[0] && y_pow == v[5:2], "R2 R4 R6 table y", {y_hit, y_pow}, {v[0], v[5:2]});
      chk(op_out == v[10], "R7 table op", op_out, v[10]);
    end
    @(negedge clk); x_in = 0; y_in = 0; op_in = 0;
    repeat (17) @(negedge clk);
    stream(1'b0, "R1 R2 R4 sweep poly0");
    load_cfg(1'b1);
    stream(1'b1, "R3 R9 sweep poly1");
    @(negedge clk); x_in = 4'd7; y_in = 4'd3; op_in = 1;
    repeat (20) @(negedge clk);
    chk(x_hit && y_hit && op_out, "R1 steady input", {x_hit, y_hit, op_out}, 7);
    rst_n = 0;
    @(negedge clk);
    chk(!x_hit && !y_hit && x_pow == 0 && y_pow == 0 && !op_out, "R8 reset mid-run",
        {x_hit, y_hit, x_pow, y_pow, op_out}, 0);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
      $finish;
    end
  end
endmodule